// File: doc/BRIEF.md
# LCD Timing Enable Generator

This block turns one fast input clock into the slower timing strobes that an LCD drive sequencer needs. It produces only single-cycle enables in the input clock domain; it never generates a clock. It has three stages. A power-of-two prescaler makes the base tick. A divider with a factor of 16 to 31 counts base ticks and makes the phase tick. A blink divider counts frame-start pulses and toggles a blink level.

Two interrupt flags sit beside the chain: start-of-frame and update-done. Each flag is set by its event pulse only while its enable input is high. It then stays high until a clear input drops it. Software or a sequencer drives the configuration fields directly. Changing a field restarts the counters it affects, so the first period after a change is never too long.

Top module: `lcd_clkgen_top`

## Requirements
- R1: With the prescale field `ps_i` = P, `ps_tick_o` pulses once every 2^P input cycles. P = 0 pulses every cycle, and P = 15 gives a period of 32768 cycles.
- R2: In the cycle in which `ps_i` differs from its value in the previous cycle, neither tick is issued. Both the prescaler and the divider restart, and the first `ps_tick_o` comes exactly 2^P cycles after that cycle.
- R3: With divide field `div_i` = D, `div_tick_o` pulses once every (16 + D) × 2^P cycles and only in a cycle where `ps_tick_o` is also high. After a cycle that restarts both counters, the first `div_tick_o` comes exactly (16 + D) × 2^P cycles later.
- R4: A change of `div_i` alone suppresses `div_tick_o` in that cycle and restarts the divider. The next `div_tick_o` coincides with the (16 + D)-th `ps_tick_o` after the change.
- R5: With blink field `blinkf_i` = B, `blink_o` inverts once every 4 × 2^B pulses of `frame_start_i`, which gives a full blink period of 8 × 2^B frames. The inversion is visible in the cycle after the counting pulse, and `blink_o` never changes in a cycle that follows one with no frame-start pulse.
- R6: A change of `blinkf_i` leaves `blink_o` as it is and restarts the frame count. The next inversion comes after 4 × 2^B further pulses.
- R7: A `frame_start_i` pulse while `sof_ie_i` is high sets `sof_irq_o` in the next cycle. The flag then stays high until `sof_clr_i`.
- R8: A `frame_start_i` pulse while `sof_ie_i` is low leaves `sof_irq_o` low.
- R9: `sof_clr_i` lowers `sof_irq_o` in the next cycle, even when a qualifying set arrives in the same cycle.
- R10: `update_done_i` controls `udd_irq_o` under `udd_ie_i` in the same way. It sets the flag in the next cycle only when enabled, and the flag stays high until cleared.
- R11: `udd_clr_i` lowers `udd_irq_o` in the next cycle, even when a qualifying set arrives in the same cycle.
- R12: While `rst_ni` is low, both ticks, both flags and `blink_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps_i | input | 4 | Prescale exponent P |
| div_i | input | 4 | Divide offset D (factor 16 + D) |
| blinkf_i | input | 3 | Blink rate select B |
| sof_ie_i | input | 1 | Start-of-frame flag enable |
| udd_ie_i | input | 1 | Update-done flag enable |
| frame_start_i | input | 1 | Frame-start pulse |
| update_done_i | input | 1 | Update-done pulse |
| sof_clr_i | input | 1 | Clear of the start-of-frame flag |
| udd_clr_i | input | 1 | Clear of the update-done flag |
| ps_tick_o | output | 1 | Prescaled tick enable |
| div_tick_o | output | 1 | Phase tick enable |
| blink_o | output | 1 | Blink level |
| sof_irq_o | output | 1 | Start-of-frame flag |
| udd_irq_o | output | 1 | Update-done flag |

## Verification
The tick outputs are combinational from registered counters. A new `ps_i` therefore yields its first tick exactly 2^P cycles after the cycle in which it is presented, and the divider tick exactly (16 + D) × 2^P cycles after it. The bench drives each change just after a falling edge and counts falling edges until the tick appears. The blink level and both flags are registered and respond one cycle after their pulse, so the bench samples them in the cycle after the pulse has been removed. It also samples once during the pulse itself, to confirm that nothing has moved early.

// File: rtl/lcd_clkgen_pkg.sv
package lcd_clkgen_pkg;
   // smallest phase divide factor
   localparam int DIV_BASE = 16;
   // frame pulses per blink half period at rate select 0
   localparam int BLINK_HALF_BASE = 4;
   // interrupt channels
   typedef enum int unsigned {
      IRQ_SOF = 0,
      IRQ_UDD = 1
   } irq_chan_e;
   localparam int IRQ_N = 2;
endpackage

// File: rtl/lcd_pow2_prescaler.sv
module lcd_pow2_prescaler #(
   parameter int SHIFT_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [SHIFT_W-1:0] shift_i,
   output logic               tick_o,
   output logic               restart_o
);
   localparam int SHIFT_MAX = (1 << SHIFT_W) - 1;
   localparam int CNT_W     = (SHIFT_MAX < 1) ? 1 : SHIFT_MAX;

   if (SHIFT_W < 1 || SHIFT_W > 5) begin : g_bad_width
      $error("lcd_pow2_prescaler: SHIFT_W must be 1..5");
   end

   logic [SHIFT_W-1:0] shift_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W:0]     lim;

   always_comb begin
      lim       = ((CNT_W+1)'(1) << shift_q) - (CNT_W+1)'(1);
      restart_o = (shift_i != shift_q);
      tick_o    = rst_ni && !restart_o && (cnt_q == lim[CNT_W-1:0]);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shift_q <= '0;
         cnt_q   <= '0;
      end else begin
         shift_q <= shift_i;
         if (restart_o || tick_o) cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lcd_phase_divider.sv
module lcd_phase_divider #(
   parameter int SEL_W = 4,
   parameter int BASE  = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             flush_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int TOP   = BASE + (1 << SEL_W) - 1;
   localparam int CNT_W = $clog2(TOP);

   if (BASE < 2 || SEL_W < 1 || SEL_W > 8) begin : g_bad_cfg
      $error("lcd_phase_divider: BASE >= 2 and SEL_W in 1..8 required");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;
   logic             restart;

   always_comb begin
      target  = CNT_W'(BASE - 1) + CNT_W'(sel_q);
      restart = flush_i || (sel_i != sel_q);
      tick_o  = step_i && !restart && (cnt_q == target);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         sel_q <= sel_i;
         if (restart)     cnt_q <= '0;
         else if (step_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lcd_blink_divider.sv
module lcd_blink_divider #(
   parameter int SEL_W     = 3,
   parameter int HALF_BASE = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             frame_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             blink_o
);
   localparam int MAX_HALF = HALF_BASE << ((1 << SEL_W) - 1);
   localparam int CNT_W    = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF);

   if (HALF_BASE < 1 || SEL_W < 1 || SEL_W > 4) begin : g_bad_cfg
      $error("lcd_blink_divider: HALF_BASE >= 1 and SEL_W in 1..4 required");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   lim;
   logic             restart, hit;

   always_comb begin
      lim     = ((CNT_W+1)'(HALF_BASE) << sel_q) - (CNT_W+1)'(1);
      restart = (sel_i != sel_q);
      hit     = frame_i && !restart && (cnt_q == lim[CNT_W-1:0]);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q   <= '0;
         cnt_q   <= '0;
         blink_o <= 1'b0;
      end else begin
         sel_q <= sel_i;
         if (restart) begin
            cnt_q <= '0;
         end else if (hit) begin
            cnt_q   <= '0;
            blink_o <= ~blink_o;
         end else if (frame_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lcd_irq_latch.sv
module lcd_irq_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic en_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              flag_o <= 1'b0;
      else if (clr_i)           flag_o <= 1'b0;
      else if (set_i && en_i)   flag_o <= 1'b1;
   end
endmodule

// File: rtl/lcd_clkgen_top.sv
module lcd_clkgen_top
   import lcd_clkgen_pkg::*;
#(
   parameter int PS_W         = 4,
   parameter int DIV_W        = 4,
   parameter int BLINK_W      = 3,
   parameter bit BLINK_ENABLE = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [PS_W-1:0]    ps_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic [BLINK_W-1:0] blinkf_i,
   input  logic               sof_ie_i,
   input  logic               udd_ie_i,
   input  logic               frame_start_i,
   input  logic               update_done_i,
   input  logic               sof_clr_i,
   input  logic               udd_clr_i,
   output logic               ps_tick_o,
   output logic               div_tick_o,
   output logic               blink_o,
   output logic               sof_irq_o,
   output logic               udd_irq_o
);
   logic ps_restart;

   lcd_pow2_prescaler #(.SHIFT_W(PS_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .shift_i   (ps_i),
      .tick_o    (ps_tick_o),
      .restart_o (ps_restart)
   );

   lcd_phase_divider #(.SEL_W(DIV_W), .BASE(DIV_BASE)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (ps_tick_o),
      .flush_i (ps_restart),
      .sel_i   (div_i),
      .tick_o  (div_tick_o)
   );

   if (BLINK_ENABLE) begin : g_blink
      lcd_blink_divider #(.SEL_W(BLINK_W), .HALF_BASE(BLINK_HALF_BASE)) u_blink (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .frame_i (frame_start_i),
         .sel_i   (blinkf_i),
         .blink_o (blink_o)
      );
   end else begin : g_no_blink
      assign blink_o = 1'b0;
   end

   logic [IRQ_N-1:0] irq_set, irq_en, irq_clr, irq_flag;

   assign irq_set[IRQ_SOF] = frame_start_i;
   assign irq_en [IRQ_SOF] = sof_ie_i;
   assign irq_clr[IRQ_SOF] = sof_clr_i;
   assign irq_set[IRQ_UDD] = update_done_i;
   assign irq_en [IRQ_UDD] = udd_ie_i;
   assign irq_clr[IRQ_UDD] = udd_clr_i;

   for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
      lcd_irq_latch u_flag (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (irq_set[g]),
         .en_i   (irq_en[g]),
         .clr_i  (irq_clr[g]),
         .flag_o (irq_flag[g])
      );
   end

   assign sof_irq_o = irq_flag[IRQ_SOF];
   assign udd_irq_o = irq_flag[IRQ_UDD];
endmodule

// File: rtl/lcd_clkgen_chk.sv
module lcd_clkgen_chk #(
   parameter int PS_W    = 4,
   parameter int DIV_W   = 4,
   parameter int BLINK_W = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [PS_W-1:0]    ps_i,
   input logic [DIV_W-1:0]   div_i,
   input logic               sof_ie_i,
   input logic               udd_ie_i,
   input logic               frame_start_i,
   input logic               update_done_i,
   input logic               sof_clr_i,
   input logic               udd_clr_i,
   input logic               ps_tick_o,
   input logic               div_tick_o,
   input logic               blink_o,
   input logic               sof_irq_o,
   input logic               udd_irq_o
);
   // R3
   div_on_ps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_tick_o |-> ps_tick_o);
   // R2
   ps_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ps_i) |-> (!ps_tick_o && !div_tick_o));
   // R4
   div_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(div_i) |-> !div_tick_o);
   // R5
   blink_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_start_i |=> $stable(blink_o));
   // R7
   sof_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sof_irq_o && !sof_clr_i) |=> sof_irq_o);
   // R8
   sof_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sof_irq_o && !(frame_start_i && sof_ie_i)) |=> !sof_irq_o);
   // R9
   sof_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sof_clr_i |=> !sof_irq_o);
   // R10
   udd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!udd_irq_o && !(update_done_i && udd_ie_i)) |=> !udd_irq_o);
   // R10
   udd_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (udd_irq_o && !udd_clr_i) |=> udd_irq_o);
   // R11
   udd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      udd_clr_i |=> !udd_irq_o);
endmodule

bind lcd_clkgen_top lcd_clkgen_chk #(.PS_W(PS_W), .DIV_W(DIV_W), .BLINK_W(BLINK_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .ps_i          (ps_i),
   .div_i         (div_i),
   .sof_ie_i      (sof_ie_i),
   .udd_ie_i      (udd_ie_i),
   .frame_start_i (frame_start_i),
   .update_done_i (update_done_i),
   .sof_clr_i     (sof_clr_i),
   .udd_clr_i     (udd_clr_i),
   .ps_tick_o     (ps_tick_o),
   .div_tick_o    (div_tick_o),
   .blink_o       (blink_o),
   .sof_irq_o     (sof_irq_o),
   .udd_irq_o     (udd_irq_o)
);

// File: tb/sim_lcd_clkgen_top.sv
`timescale 1ns/1ps
module sim_lcd_clkgen_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ps = 4'd3;
   logic [3:0] dv = 4'd0;
   logic [2:0] bf = 3'd0;
   logic [1:0] ie = 2'b00;
   logic [1:0] ev = 2'b00;
   logic [1:0] clr = 2'b00;
   logic       ps_tick, div_tick, blink;
   logic [1:0] irq;
   int         nchk = 0;
   int         nfail = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   lcd_clkgen_top u0 (
      .clk_i(clk), .rst_ni(rst_n), .ps_i(ps), .div_i(dv), .blinkf_i(bf),
      .sof_ie_i(ie[0]), .udd_ie_i(ie[1]),
      .frame_start_i(ev[0]), .update_done_i(ev[1]),
      .sof_clr_i(clr[0]), .udd_clr_i(clr[1]),
      .ps_tick_o(ps_tick), .div_tick_o(div_tick), .blink_o(blink),
      .sof_irq_o(irq[0]), .udd_irq_o(irq[1])
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick_cycle();
      @(negedge clk); #1;
   endtask

   // R1 / R2: prescaler latency after a change and period
   task automatic ps_run(input int p, input bit period);
      longint k;
      @(negedge clk); ps = 4'(p); #1;
      check(!ps_tick, "R2 tick in change cycle", ps_tick, 0);
      k = 0;
      do begin tick_cycle(); k++; end while (!ps_tick && k < 70000);
      check(k == (64'd1 << p), "R2 first tick latency", k, 64'd1 << p);
      if (period) begin
         k = 0;
         do begin tick_cycle(); k++; end while (!ps_tick && k < 70000);
         check(k == (64'd1 << p), "R1 tick period", k, 64'd1 << p);
      end
   endtask

   // R3: divider latency after full restart, period, coincidence
   task automatic div_run(input int p, input int d);
      longint k, e;
      @(negedge clk); ps = 4'((p + 1) % 16);
      @(negedge clk); ps = 4'(p); dv = 4'(d); #1;
      e = (16 + d) << p;
      k = 0;
      do begin tick_cycle(); k++; end while (!div_tick && k < 5000);
      check(k == e, "R3 first phase tick latency", k, e);
      check(ps_tick, "R3 phase tick with base tick", ps_tick, 1);
      k = 0;
      do begin tick_cycle(); k++; end while (!div_tick && k < 5000);
      check(k == e, "R3 phase tick period", k, e);
   endtask

   // R4: change of div_i alone
   task automatic div_only(input int d);
      int n, k;
      do tick_cycle(); while (!ps_tick);
      @(negedge clk); dv = 4'(d); #1;
      check(!div_tick, "R4 no phase tick in change cycle", div_tick, 0);
      n = 0; k = 0;
      do begin
         tick_cycle(); k++;
         if (ps_tick) n++;
      end while (!div_tick && k < 5000);
      check(n == 16 + d, "R4 base ticks until phase tick", n, 16 + d);
   endtask

   // R5 / R6: blink
   task automatic frame_pulse();
      @(negedge clk); ev[0] = 1'b1;
      @(negedge clk); ev[0] = 1'b0; #1;
   endtask

   task automatic blink_run(input int b);
      logic lvl;
      int   n;
      @(negedge clk); ev[0] = 1'b0; bf = 3'(b); lvl = blink;
      tick_cycle();
      check(blink == lvl, "R6 level kept on rate change", blink, lvl);
      n = 0;
      do begin frame_pulse(); n++; end while (blink == lvl && n < 2000);
      check(n == (4 << b), "R6 pulses to first toggle", n, 4 << b);
      lvl = blink; n = 0;
      do begin
         @(negedge clk); ev[0] = 1'b1; #1;
         if (n == 0) check(blink == lvl, "R5 no change during pulse", blink, lvl);
         @(negedge clk); ev[0] = 1'b0; #1;
         n++;
      end while (blink == lvl && n < 2000);
      check(n == (4 << b), "R5 pulses per half period", n, 4 << b);
   endtask

   // R7 to R11: interrupt flags
   task automatic irq_run(input int c);
      string rs, rg, rc;
      rs = (c == 0) ? "R7"  : "R10";
      rg = (c == 0) ? "R8"  : "R10";
      rc = (c == 0) ? "R9"  : "R11";
      @(negedge clk); ie[c] = 1'b0; ev[c] = 1'b1;
      @(negedge clk); ev[c] = 1'b0; #1;
      check(!irq[c], {rg, " disabled event ignored"}, irq[c], 0);
      @(negedge clk); ie[c] = 1'b1; ev[c] = 1'b1; #1;
      check(!irq[c], {rs, " not set early"}, irq[c], 0);
      @(negedge clk); ev[c] = 1'b0; #1;
      check(irq[c], {rs, " set after event"}, irq[c], 1);
      repeat (5) tick_cycle();
      check(irq[c], {rs, " sticky"}, irq[c], 1);
      @(negedge clk); clr[c] = 1'b1;
      @(negedge clk); clr[c] = 1'b0; #1;
      check(!irq[c], {rc, " clear"}, irq[c], 0);
      @(negedge clk); ev[c] = 1'b1; clr[c] = 1'b1;
      @(negedge clk); ev[c] = 1'b0; clr[c] = 1'b0; #1;
      check(!irq[c], {rc, " clear beats set"}, irq[c], 0);
      @(negedge clk); ev[c] = 1'b1;
      @(negedge clk); ev[c] = 1'b0; #1;
      check(irq[c], {rs, " set again"}, irq[c], 1);
      @(negedge clk); clr[c] = 1'b1;
      @(negedge clk); clr[c] = 1'b0;
   endtask

   initial begin
      #1900000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      ps = 4'd0; #1;
      // R12 reset state
      check({ps_tick, div_tick, blink, irq} == 5'b0, "R12 reset outputs", {ps_tick, div_tick, blink, irq}, 0);
      @(negedge clk); rst_n = 1'b1; ps = 4'd5;
      for (int p = 0; p <= 10; p++) ps_run(p, 1'b1);
      ps_run(15, 1'b0);
      for (int p = 0; p <= 3; p++)
         for (int d = 0; d <= 15; d++) div_run(p, d);
      @(negedge clk); ps = 4'd2;
      div_only(0);
      div_only(9);
      div_only(15);
      for (int b = 1; b <= 7; b++) blink_run(b);
      blink_run(0);
      irq_run(0);
      irq_run(1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule